// File: doc/BRIEF.md
# Programmable 3x3 Colour Space Converter

This block converts a stream of pixels, each carrying three 10-bit components, through a programmable affine colour transform. The channel order is Cr, Y/G, Cb. Each converted pixel passes through five steps: a per-channel input clamp, an input offset, a 3x3 signed fixed-point matrix, an output offset and an unsigned output clamp. A typical use converts limited-range YCbCr into full-range 10-bit RGB. The chroma components arrive as signed values, because the mid-scale bias has been removed before this block.

Software programs the offsets, the nine coefficients and the clamp limits through a plain register write port. Those writes land in a shadow bank. The bank becomes active only on a frame-start strobe, and the per-frame format flag is sampled on the same strobe. When the active frame is marked RGB, every pixel leaves unchanged. Pixels enter and leave through valid/ready handshakes, and both modes take the same three-register path, so timing does not depend on the mode.

Top module: `color_matrix_xform`

## Requirements
- R1: After reset, pix_out_valid is 0 and pix_in_ready is 1. The active and shadow settings hold an identity matrix (4096 on the diagonal, 0 elsewhere), zero offsets, input clamp -1024..1023, output clamp 0..1023 and RGB mode.
- R2: Register map (cfg_wr_addr). Addresses 0/1/2 hold the Cr/Y/Cb offsets: output offset in bits 26:16 and input offset in bits 10:0, both signed 11-bit. Address 3+p holds coefficient 2p in bits 14:0 and coefficient 2p+1 in bits 30:16, for p = 0..4; coefficient 8 is alone at address 7. Coefficient k sits in row k/3 and column k%3. Addresses 8/9/10 hold the Cr/Y/Cb input clamp: max in bits 26:16 and min in bits 10:0, signed 11-bit. Addresses 11/12/13 hold the output clamp: max in bits 25:16 and min in bits 9:0, unsigned 10-bit.
- R3: Register writes and frame_is_yuv have no effect on pixels until a cycle with frame_start high. That strobe copies the whole shadow bank into the active bank and samples frame_is_yuv (1 = YCbCr, 0 = RGB).
- R4: In RGB mode, each output pixel equals its input pixel bit for bit, whatever the register contents.
- R5: In YCbCr mode, each raw component is first limited to at most max and then to at least min, so min wins when min > max. The input offset is then added.
- R6: Output channel k is the sum over j of C[k][j] times the offset-adjusted input j, plus the output offset of k. Coefficients are s3.12, so 4096 means 1.0.
- R7: The matrix sum is kept at full width and rounded by adding 2048 and shifting right arithmetically by 12. This rounding happens before the output offset.
- R8: The output offset is added to the rounded value. The result is then limited to at most the output max and then to at least the output min, giving a 10-bit unsigned value.
- R9: With pix_out_ready held high, an accepted pixel appears on the output after the second rising edge following the accepting edge. This is the same in both modes.
- R10: While pix_out_valid is 1 and pix_out_ready is 0, the output data holds and pix_in_ready is 0. No pixel is lost, duplicated or reordered.
- R11: Pixel packing: Cr in bits 9:0, Y/G in bits 19:10, Cb in bits 29:20. Y/G is unsigned, and Cr and Cb are two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 4 | Register address |
| cfg_wr_data | input | 32 | Register write data |
| frame_start | input | 1 | Frame boundary: activate shadow settings and sample the format flag |
| frame_is_yuv | input | 1 | Format of the coming frame (1 YCbCr, 0 RGB) |
| pix_in_valid | input | 1 | Input pixel valid |
| pix_in_ready | output | 1 | Input pixel accepted this cycle when high with valid |
| pix_in_data | input | 30 | Input pixel {Cb, Y/G, Cr} |
| pix_out_valid | output | 1 | Output pixel valid |
| pix_out_ready | input | 1 | Downstream can take the output pixel |
| pix_out_data | output | 30 | Output pixel {Cb, Y/G, Cr} |

## Verification
The output-range assertion assumes that the programmed output min is not above the max; where that does not hold, it does not check. The hold and stall assertions assume that a valid output is taken only when pix_out_ready is high, with inputs free of unknowns after reset. The stimulus pulses frame_start only when no pixel is inside the pipeline, so every pixel sees a single coefficient set. It also keeps the matrix sum far inside the accumulator width, including with the reference limited-range coefficients at the extremes of the clamp ranges.

// File: rtl/cmx_pkg.sv
package cmx_pkg;
   localparam int NCH   = 3;
   localparam int NCOEF = NCH * NCH;
   localparam int CH_CR = 0;
   localparam int CH_YG = 1;
   localparam int CH_CB = 2;
   // register address bases; channel or coefficient pair index is added
   localparam logic [3:0] A_OFS0  = 4'd0;
   localparam logic [3:0] A_COEF0 = 4'd3;
   localparam logic [3:0] A_ICLP0 = 4'd8;
   localparam logic [3:0] A_OCLP0 = 4'd11;
   // bit position of the upper field in every register word
   localparam int FIELD_HI = 16;
endpackage

// File: rtl/cmx_sat.sv
module cmx_sat #(
   parameter int W = 12
) (
   input  logic signed [W-1:0] val,
   input  logic signed [W-1:0] lo,
   input  logic signed [W-1:0] hi,
   output logic signed [W-1:0] res
);
   logic signed [W-1:0] capped;
   // upper limit first, lower limit last: lower bound wins on a crossed pair
   always_comb begin
      capped = (val > hi) ? hi : val;
      res    = (capped < lo) ? lo : capped;
   end
endmodule

// File: rtl/cmx_cfg.sv
module cmx_cfg
   import cmx_pkg::*;
#(
   parameter int DW = 10,
   parameter int CW = 15,
   parameter int FB = 12,
   parameter int OW = 11
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [3:0]                  wr_addr,
   input  logic [31:0]                 wr_data,
   input  logic                        frame_start,
   input  logic                        fmt_yuv,
   output logic [NCH-1:0][OW-1:0]      ioff,
   output logic [NCH-1:0][OW-1:0]      ooff,
   output logic [NCH-1:0][OW-1:0]      imin,
   output logic [NCH-1:0][OW-1:0]      imax,
   output logic [NCH-1:0][DW-1:0]      omin,
   output logic [NCH-1:0][DW-1:0]      omax,
   output logic [NCOEF-1:0][CW-1:0]    coef,
   output logic                        yuv
);
   localparam logic [OW-1:0] IMIN_RST = {1'b1, {(OW-1){1'b0}}};
   localparam logic [OW-1:0] IMAX_RST = {1'b0, {(OW-1){1'b1}}};
   localparam logic [CW-1:0] UNITY    = CW'(1 << FB);

   logic [NCH-1:0][OW-1:0]   sh_ioff, sh_ooff, sh_imin, sh_imax;
   logic [NCH-1:0][DW-1:0]   sh_omin, sh_omax;
   logic [NCOEF-1:0][CW-1:0] sh_coef;

   logic unused_wr_bits;
   assign unused_wr_bits = ^wr_data;

   // shadow bank: software writes land here
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            sh_ioff[c] <= '0;
            sh_ooff[c] <= '0;
            sh_imin[c] <= IMIN_RST;
            sh_imax[c] <= IMAX_RST;
            sh_omin[c] <= '0;
            sh_omax[c] <= '1;
         end
         for (int k = 0; k < NCOEF; k++)
            sh_coef[k] <= (k % (NCH + 1) == 0) ? UNITY : '0;
      end else if (wr_en) begin
         for (int c = 0; c < NCH; c++) begin
            if (wr_addr == A_OFS0 + 4'(c)) begin
               sh_ioff[c] <= wr_data[OW-1:0];
               sh_ooff[c] <= wr_data[FIELD_HI +: OW];
            end
            if (wr_addr == A_ICLP0 + 4'(c)) begin
               sh_imin[c] <= wr_data[OW-1:0];
               sh_imax[c] <= wr_data[FIELD_HI +: OW];
            end
            if (wr_addr == A_OCLP0 + 4'(c)) begin
               sh_omin[c] <= wr_data[DW-1:0];
               sh_omax[c] <= wr_data[FIELD_HI +: DW];
            end
         end
         for (int k = 0; k < NCOEF; k += 2)
            if (wr_addr == A_COEF0 + 4'(k / 2))
               sh_coef[k] <= wr_data[CW-1:0];
         for (int k = 1; k < NCOEF; k += 2)
            if (wr_addr == A_COEF0 + 4'(k / 2))
               sh_coef[k] <= wr_data[FIELD_HI +: CW];
      end
   end

   // active bank: copied whole at the frame boundary
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            ioff[c] <= '0;
            ooff[c] <= '0;
            imin[c] <= IMIN_RST;
            imax[c] <= IMAX_RST;
            omin[c] <= '0;
            omax[c] <= '1;
         end
         for (int k = 0; k < NCOEF; k++)
            coef[k] <= (k % (NCH + 1) == 0) ? UNITY : '0;
         yuv <= 1'b0;
      end else if (frame_start) begin
         ioff <= sh_ioff;
         ooff <= sh_ooff;
         imin <= sh_imin;
         imax <= sh_imax;
         omin <= sh_omin;
         omax <= sh_omax;
         coef <= sh_coef;
         yuv  <= fmt_yuv;
      end
   end

   // R3: active settings move only on the strobe
   a_r3_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> ($stable(coef) && $stable(ioff) && $stable(ooff) &&
                        $stable(imin) && $stable(imax) && $stable(omin) &&
                        $stable(omax) && $stable(yuv)));
endmodule

// File: rtl/cmx_pipe.sv
module cmx_pipe
   import cmx_pkg::*;
#(
   parameter int DW = 10,
   parameter int CW = 15,
   parameter int FB = 12,
   parameter int OW = 11
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        adv,
   input  logic                        in_valid,
   input  logic [NCH*DW-1:0]           in_pix,
   input  logic [NCH-1:0][OW-1:0]      ioff,
   input  logic [NCH-1:0][OW-1:0]      ooff,
   input  logic [NCH-1:0][OW-1:0]      imin,
   input  logic [NCH-1:0][OW-1:0]      imax,
   input  logic [NCH-1:0][DW-1:0]      omin,
   input  logic [NCH-1:0][DW-1:0]      omax,
   input  logic [NCOEF-1:0][CW-1:0]    coef,
   input  logic                        yuv,
   output logic                        out_valid,
   output logic [NCH*DW-1:0]           out_pix
);
   localparam int XW     = OW + 1;          // clamped + offset operand
   localparam int PW     = CW + XW;         // one product
   localparam int SW     = PW + 2;          // sum of three products
   localparam int VW     = SW + 1;          // rounded + output offset
   localparam int HALF_I = 1 << (FB - 1);
   localparam logic [SW-1:0] HALF_V = SW'(HALF_I);

   logic                      v1, v2;
   logic                      s1_yuv, s2_yuv;
   logic [NCH*DW-1:0]         s1_raw, s2_raw;
   logic [NCH-1:0][XW-1:0]    x_pre, s1_x;
   logic [NCH-1:0][SW-1:0]    acc_pre, s2_acc;
   logic [NCH-1:0][DW-1:0]    y_pre;
   logic [NCH*DW-1:0]         out_pre;

   // stage 1: input clamp then input offset
   for (genvar ch = 0; ch < NCH; ch++) begin : g_in
      logic signed [XW-1:0] x_ext, x_cl;
      if (ch == CH_YG) begin : g_uns
         assign x_ext = {{(XW-DW){1'b0}}, in_pix[ch*DW +: DW]};
      end else begin : g_sgn
         assign x_ext = {{(XW-DW){in_pix[ch*DW+DW-1]}}, in_pix[ch*DW +: DW]};
      end
      cmx_sat #(.W(XW)) u_isat (
         .val (x_ext),
         .lo  ({imin[ch][OW-1], imin[ch]}),
         .hi  ({imax[ch][OW-1], imax[ch]}),
         .res (x_cl)
      );
      assign x_pre[ch] = x_cl + {ioff[ch][OW-1], ioff[ch]};
   end

   // stage 2: matrix rows at full precision
   for (genvar k = 0; k < NCH; k++) begin : g_row
      logic [NCH-1:0][PW-1:0] prod;
      for (genvar j = 0; j < NCH; j++) begin : g_col
         assign prod[j] =
            $signed({{(PW-CW){coef[k*NCH+j][CW-1]}}, coef[k*NCH+j]}) *
            $signed({{(PW-XW){s1_x[j][XW-1]}}, s1_x[j]});
      end
      assign acc_pre[k] = {{2{prod[0][PW-1]}}, prod[0]} +
                          {{2{prod[1][PW-1]}}, prod[1]} +
                          {{2{prod[2][PW-1]}}, prod[2]};
   end

   // stage 3: round, output offset, output clamp
   for (genvar k = 0; k < NCH; k++) begin : g_out
      logic signed [SW-1:0] rnd_sum, rnd;
      logic signed [VW-1:0] w_off, o_cl;
      logic                 unused_hi;
      assign rnd_sum = s2_acc[k] + HALF_V;
      assign rnd     = rnd_sum >>> FB;
      assign w_off   = {rnd[SW-1], rnd} + {{(VW-OW){ooff[k][OW-1]}}, ooff[k]};
      cmx_sat #(.W(VW)) u_osat (
         .val (w_off),
         .lo  ({{(VW-DW){1'b0}}, omin[k]}),
         .hi  ({{(VW-DW){1'b0}}, omax[k]}),
         .res (o_cl)
      );
      assign y_pre[k]  = o_cl[DW-1:0];
      assign unused_hi = ^o_cl[VW-1:DW];

      // R8: a converted result never leaves the programmed output window
      a_r8_out_in_range: assert property (@(posedge clk) disable iff (!rst_n)
         (adv && v2 && s2_yuv && (omin[k] <= omax[k])) |=>
         ((out_pix[k*DW +: DW] >= $past(omin[k])) &&
          (out_pix[k*DW +: DW] <= $past(omax[k]))));
   end

   assign out_pre = s2_yuv ? y_pre : s2_raw;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1 <= 1'b0;  v2 <= 1'b0;  out_valid <= 1'b0;
         s1_yuv <= 1'b0;  s2_yuv <= 1'b0;
         s1_raw <= '0;  s2_raw <= '0;
         s1_x <= '0;  s2_acc <= '0;  out_pix <= '0;
      end else if (adv) begin
         v1        <= in_valid;
         s1_raw    <= in_pix;
         s1_yuv    <= yuv;
         s1_x      <= x_pre;
         v2        <= v1;
         s2_raw    <= s1_raw;
         s2_yuv    <= s1_yuv;
         s2_acc    <= acc_pre;
         out_valid <= v2;
         out_pix   <= out_pre;
      end
   end
endmodule

// File: rtl/color_matrix_xform.sv
module color_matrix_xform
   import cmx_pkg::*;
#(
   parameter int DW = 10,
   parameter int CW = 15,
   parameter int FB = 12,
   parameter int OW = 11
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr_en,
   input  logic [3:0]           cfg_wr_addr,
   input  logic [31:0]          cfg_wr_data,
   input  logic                 frame_start,
   input  logic                 frame_is_yuv,
   input  logic                 pix_in_valid,
   output logic                 pix_in_ready,
   input  logic [NCH*DW-1:0]    pix_in_data,
   output logic                 pix_out_valid,
   input  logic                 pix_out_ready,
   output logic [NCH*DW-1:0]    pix_out_data
);
   initial begin : p_param_chk
      if (DW < 2 || DW > FIELD_HI) $fatal(1, "DW out of range");
      if (OW <= DW || OW > FIELD_HI) $fatal(1, "OW must exceed DW and fit a field");
      if (CW > FIELD_HI || FB >= CW - 1 || FB < 1) $fatal(1, "coefficient format invalid");
   end

   logic [NCH-1:0][OW-1:0]   ioff, ooff, imin, imax;
   logic [NCH-1:0][DW-1:0]   omin, omax;
   logic [NCOEF-1:0][CW-1:0] coef;
   logic                     yuv;
   logic                     adv;

   assign adv          = !pix_out_valid || pix_out_ready;
   assign pix_in_ready = adv;

   cmx_cfg #(.DW(DW), .CW(CW), .FB(FB), .OW(OW)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr),
      .wr_data(cfg_wr_data), .frame_start(frame_start), .fmt_yuv(frame_is_yuv),
      .ioff(ioff), .ooff(ooff), .imin(imin), .imax(imax),
      .omin(omin), .omax(omax), .coef(coef), .yuv(yuv)
   );

   cmx_pipe #(.DW(DW), .CW(CW), .FB(FB), .OW(OW)) u_pipe (
      .clk(clk), .rst_n(rst_n), .adv(adv), .in_valid(pix_in_valid),
      .in_pix(pix_in_data), .ioff(ioff), .ooff(ooff), .imin(imin),
      .imax(imax), .omin(omin), .omax(omax), .coef(coef), .yuv(yuv),
      .out_valid(pix_out_valid), .out_pix(pix_out_data)
   );

   // R10: a refused output stays put
   a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_out_valid && !pix_out_ready) |=> (pix_out_valid && $stable(pix_out_data)));

   // R10: a full, blocked pipe refuses new pixels
   a_r10_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_out_valid && !pix_out_ready) |-> !pix_in_ready);
endmodule

// File: tb/color_matrix_xform_tb.sv
module color_matrix_xform_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_wr_en;
   logic [3:0]  cfg_wr_addr;
   logic [31:0] cfg_wr_data;
   logic        frame_start, frame_is_yuv;
   logic        pix_in_valid, pix_in_ready;
   logic [29:0] pix_in_data;
   logic        pix_out_valid, pix_out_ready;
   logic [29:0] pix_out_data;

   int n_chk = 0;
   int n_bad = 0;
   logic        bp_en = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   // bench copy of the settings, built from the requirements
   int s_ioff[3], s_ooff[3], s_imin[3], s_imax[3], s_omin[3], s_omax[3], s_coef[9];
   int a_ioff[3], a_ooff[3], a_imin[3], a_imax[3], a_omin[3], a_omax[3], a_coef[9];
   bit a_yuv;

   logic [29:0] exp_q[$];
   logic [29:0] got_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   color_matrix_xform u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
      .cfg_wr_data(cfg_wr_data), .frame_start(frame_start), .frame_is_yuv(frame_is_yuv),
      .pix_in_valid(pix_in_valid), .pix_in_ready(pix_in_ready), .pix_in_data(pix_in_data),
      .pix_out_valid(pix_out_valid), .pix_out_ready(pix_out_ready),
      .pix_out_data(pix_out_data)
   );

   always @(posedge clk) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (!rst_n) pix_out_ready <= 1'b1;
      else        pix_out_ready <= bp_en ? (lfsr[0] | lfsr[3]) : 1'b1;
   end

   always @(negedge clk)
      if (rst_n && pix_out_valid && pix_out_ready) got_q.push_back(pix_out_data);

   task automatic chk(input bit ok, input string req, input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic int sx10(input logic [9:0] v);
      return v[9] ? int'(v) - 1024 : int'(v);
   endfunction

   function automatic logic [29:0] model(input logic [29:0] p);
      logic [29:0] r;
      if (!a_yuv) return p;
      r = '0;
      for (int k = 0; k < 3; k++) begin
         longint acc = 0;
         longint v;
         for (int j = 0; j < 3; j++) begin
            int x = (j == 1) ? int'(p[j*10 +: 10]) : sx10(p[j*10 +: 10]);
            if (x > a_imax[j]) x = a_imax[j];
            if (x < a_imin[j]) x = a_imin[j];
            x = x + a_ioff[j];
            acc += longint'(a_coef[k*3+j]) * longint'(x);
         end
         v = ((acc + 2048) >>> 12) + a_ooff[k];
         if (v > a_omax[k]) v = a_omax[k];
         if (v < a_omin[k]) v = a_omin[k];
         r[k*10 +: 10] = v[9:0];
      end
      return r;
   endfunction

   function automatic logic [29:0] pk(input int cr, input int y, input int cb);
      return {cb[9:0], y[9:0], cr[9:0]};
   endfunction

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
      @(posedge clk); @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   task automatic set_ofs(input int ch, input int io, input int oo);
      wr(4'(ch), {5'b0, oo[10:0], 5'b0, io[10:0]});
      s_ioff[ch] = io; s_ooff[ch] = oo;
   endtask

   task automatic set_iclp(input int ch, input int mn, input int mx);
      wr(4'(8 + ch), {5'b0, mx[10:0], 5'b0, mn[10:0]});
      s_imin[ch] = mn; s_imax[ch] = mx;
   endtask

   task automatic set_oclp(input int ch, input int mn, input int mx);
      wr(4'(11 + ch), {6'b0, mx[9:0], 6'b0, mn[9:0]});
      s_omin[ch] = mn; s_omax[ch] = mx;
   endtask

   task automatic set_coefs(input int c0, c1, c2, c3, c4, c5, c6, c7, c8);
      int c[9] = '{c0, c1, c2, c3, c4, c5, c6, c7, c8};
      for (int p = 0; p < 5; p++) begin
         int hi = (2*p+1 < 9) ? c[2*p+1] : 0;
         wr(4'(3 + p), {1'b0, hi[14:0], 1'b0, c[2*p][14:0]});
      end
      for (int k = 0; k < 9; k++) s_coef[k] = c[k];
   endtask

   task automatic set_default();
      set_coefs(4096, 0, 0, 0, 4096, 0, 0, 0, 4096);
      for (int ch = 0; ch < 3; ch++) begin
         set_ofs(ch, 0, 0); set_iclp(ch, -1024, 1023); set_oclp(ch, 0, 1023);
      end
   endtask

   task automatic frame(input bit y);
      frame_start = 1'b1; frame_is_yuv = y;
      @(posedge clk); @(negedge clk);
      frame_start = 1'b0; frame_is_yuv = ~y;   // flag must be ignored off-strobe
      a_ioff = s_ioff; a_ooff = s_ooff; a_imin = s_imin; a_imax = s_imax;
      a_omin = s_omin; a_omax = s_omax; a_coef = s_coef; a_yuv = y;
   endtask

   task automatic push(input logic [29:0] p);
      bit r;
      pix_in_valid = 1'b1; pix_in_data = p;
      exp_q.push_back(model(p));
      do begin
         r = pix_in_ready;
         @(posedge clk); @(negedge clk);
      end while (!r);
      pix_in_valid = 1'b0;
   endtask

   task automatic drain_cmp(input string req);
      int t = 0;
      while (got_q.size() < exp_q.size() && t < 500) begin
         @(negedge clk); t++;
      end
      repeat (4) @(negedge clk);
      chk(got_q.size() == exp_q.size(), {req, " count"}, got_q.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
         chk(got_q[i] === exp_q[i], req, got_q[i], exp_q[i]);
      exp_q.delete(); got_q.delete();
   endtask

   // R1: reset state and identity defaults
   task automatic t_reset();
      chk(pix_out_valid == 1'b0, "R1 out_valid", pix_out_valid, 0);
      chk(pix_in_ready == 1'b1, "R1 in_ready", pix_in_ready, 1);
      frame(1'b1);
      push(pk(100, 500, 200));
      push(pk(-5, 1023, 511));   // R11: Y is unsigned, chroma signed
      push(pk(0, 0, -512));
      drain_cmp("R1 identity");
   endtask

   // R4: RGB bypass ignores settings
   task automatic t_rgb();
      set_coefs(0, -7, 100, 3, 0, 0, 9, 9, 0);
      set_ofs(1, 300, -200); set_oclp(0, 500, 600);
      frame(1'b0);
      push(30'h3FFF_FFFF); push(30'h0); push(pk(-1, 5, 300)); push(30'h1555_5555);
      drain_cmp("R4 bypass");
   endtask

   // R2 R6 R11: reference limited-range programming
   task automatic t_ref();
      set_coefs(6537, 4769, 0, -3330, 4769, -1605, 0, 4769, 8263);
      set_ofs(0, 0, 0); set_ofs(1, -64, 0); set_ofs(2, 0, 0);
      set_iclp(0, -448, 448); set_iclp(1, 64, 940); set_iclp(2, -448, 448);
      for (int ch = 0; ch < 3; ch++) set_oclp(ch, 0, 1023);
      frame(1'b1);
      push(pk(0, 64, 0)); push(pk(0, 940, 0)); push(pk(448, 940, -448));
      push(pk(-448, 64, 448)); push(pk(-512, 10, 511)); push(pk(120, 500, -60));
      drain_cmp("R6 matrix");
   endtask

   // R7: rounding before output offset
   task automatic t_round();
      set_default();
      set_coefs(2048, 0, 0, 0, 2048, 0, 0, 0, 2048);
      set_ofs(0, 0, 5);
      frame(1'b1);
      push(pk(-1, 1, 0)); push(pk(-3, 2, 0)); push(pk(-2, 3, 1)); push(pk(7, 1023, -1));
      drain_cmp("R7 round");
   endtask

   // R5 R8: clamp ordering
   task automatic t_clamp();
      set_default();
      set_iclp(1, 600, 500);              // crossed: min wins
      set_ofs(1, 10, 50);
      set_oclp(2, 100, 200);
      set_iclp(0, -20, 30); set_ofs(0, 40, 0);
      frame(1'b1);
      push(pk(100, 0, 50)); push(pk(-100, 1023, 300)); push(pk(0, 550, 150));
      drain_cmp("R5 R8 clamp");
   endtask

   // R3: writes and flag wait for the strobe
   task automatic t_shadow();
      set_default();
      frame(1'b1);
      set_coefs(0, 0, 0, 0, 0, 0, 0, 0, 0);
      set_ofs(0, 0, 77);
      frame_is_yuv = 1'b0;
      push(pk(10, 20, 30));
      drain_cmp("R3 before strobe");
      frame(1'b1);
      push(pk(10, 20, 30));
      drain_cmp("R3 after strobe");
   endtask

   // R9: three-register latency in both modes
   task automatic t_latency();
      for (int m = 0; m < 2; m++) begin
         int k = 0;
         frame(m[0]);
         push(pk(1, 2, 3));
         while (!pix_out_valid && k < 10) begin
            @(posedge clk); @(negedge clk); k++;
         end
         chk(k == 2, "R9 latency", k, 2);
         drain_cmp("R9 data");
      end
   endtask

   // R10: random backpressure
   task automatic t_backpressure();
      set_coefs(6537, 4769, 0, -3330, 4769, -1605, 0, 4769, 8263);
      set_ofs(1, -64, 0);
      frame(1'b1);
      bp_en = 1'b1;
      for (int i = 0; i < 40; i++) push(30'((i * 32'h0123_4567) ^ (i << 7)));
      bp_en = 1'b0;
      drain_cmp("R10 stream");
   endtask

   initial begin
      rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_addr = '0; cfg_wr_data = '0;
      frame_start = 1'b0; frame_is_yuv = 1'b0; pix_in_valid = 1'b0; pix_in_data = '0;
      for (int c = 0; c < 3; c++) begin
         s_ioff[c] = 0; s_ooff[c] = 0; s_imin[c] = -1024; s_imax[c] = 1023;
         s_omin[c] = 0; s_omax[c] = 1023;
      end
      for (int k = 0; k < 9; k++) s_coef[k] = (k % 4 == 0) ? 4096 : 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(pix_out_valid == 1'b0, "R1 in reset", pix_out_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rgb();
      t_ref();
      t_round();
      t_clamp();
      t_shadow();
      t_latency();
      t_backpressure();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule